// File: doc/BRIEF.md
# Weighted Waveform Mixer

This block merges several oscillator sample streams into a single audio sample. Each lane carries an unsigned 24-bit sample and its own unsigned 32-bit gain. The gain is read as a pure fraction: the all-ones code is just under unity and zero is silence. On every cycle where the input strobe is high, the block scales each lane by its gain and adds the scaled lanes together. It then brings the total back to the sample width by dropping the fractional bits and sharing the headroom among the lanes.

The datapath has two registered stages. The first stage forms and holds the products. The second stage adds them, normalizes the total, clamps it and registers the mixed sample. A new set of lanes can enter on every cycle, and each result appears exactly two cycles after its inputs. Samples are always treated as offset-binary unsigned values, never as two's complement.

Top module: `wave_blend`

## Requirements
- R1: For each accepted input set, mix_o equals min(2^24-1, floor(Σ samp[i]·gain[i] / 2^(32+H))), where lane i occupies bits [24i+23:24i] of samp_i and [32i+31:32i] of gain_i. H is the headroom shift parameter, which defaults to ceil(log2 NUM_SRC) (2 for four lanes).
- R2: Samples are unsigned. A lane value of 0xFFFFFF counts as 16777215, so four full-scale lanes at gain 0xFFFFFFFF give 0xFFFFFE.
- R3: out_vld rises exactly two clock cycles after each cycle on which in_vld is high, and at no other time.
- R4: Input sets on consecutive cycles each produce their own result on consecutive cycles, in arrival order.
- R5: While out_vld is low, mix_o holds its last value.
- R6: When H is set below ceil(log2 NUM_SRC) and the normalized total exceeds 2^24-1, mix_o is clamped to 0xFFFFFF instead of wrapping. Totals that fit pass through unchanged.
- R7: A synchronous active-high reset clears both stages, so out_vld and mix_o read 0 on the first cycle after reset, and a set accepted just before reset is dropped.
- R8: If every gain is zero, the result is zero whatever the samples are.
- R9: Fractional bits are truncated toward zero, not rounded.
- R10: Sample and gain values presented while in_vld is low do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input set strobe |
| samp_i | input | NUM_SRC*SAMP_W | Packed unsigned lane samples, lane 0 in the low bits |
| gain_i | input | NUM_SRC*GAIN_W | Packed unsigned fractional lane gains, lane 0 in the low bits |
| out_vld | output | 1 | Mixed sample strobe |
| mix_o | output | SAMP_W | Mixed unsigned sample |

## Verification
A stage register that drops or repeats its valid bit shows up as a missing, extra or misplaced out_vld pulse two cycles after the input strobe. A scoreboard that stamps each expected result with its arrival cycle catches this on the very next output. A corrupted product or a wrong normalization shift shows as an arithmetic mismatch on the same result, and a register that loads while idle shows as mix_o drifting between strobes. The clamp path is covered by a second instance with reduced headroom, because its overflow cannot happen at the default setting.

// File: rtl/wave_blend_pkg.sv
package wave_blend_pkg;
    // Default geometry of the mixer
    localparam int unsigned DEF_NUM_SRC = 4;
    localparam int unsigned DEF_SAMP_W  = 24;
    localparam int unsigned DEF_GAIN_W  = 32;
endpackage

// File: rtl/wb_mul_stage.sv
// Stage one: per-lane products registered together with the strobe.
module wb_mul_stage #(
    parameter int unsigned NUM_SRC = wave_blend_pkg::DEF_NUM_SRC,
    parameter int unsigned SAMP_W  = wave_blend_pkg::DEF_SAMP_W,
    parameter int unsigned GAIN_W  = wave_blend_pkg::DEF_GAIN_W,
    localparam int unsigned PROD_W = SAMP_W + GAIN_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        vld_i,
    input  logic [NUM_SRC*SAMP_W-1:0]   samp_i,
    input  logic [NUM_SRC*GAIN_W-1:0]   gain_i,
    output logic                        vld_o,
    output logic [NUM_SRC*PROD_W-1:0]   prod_o
);
    typedef struct packed {
        logic                            vld;
        logic [NUM_SRC-1:0][PROD_W-1:0]  prod;
    } mul_st_t;

    mul_st_t st_d, st_q;
    logic [NUM_SRC-1:0][PROD_W-1:0] lane_prod;

    for (genvar l = 0; l < NUM_SRC; l++) begin : g_lane
        assign lane_prod[l] = PROD_W'(samp_i[l*SAMP_W +: SAMP_W])
                            * PROD_W'(gain_i[l*GAIN_W +: GAIN_W]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.prod = lane_prod;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.vld;
    assign prod_o = st_q.prod;
endmodule

// File: rtl/wb_norm.sv
// Combinational scaling of the lane total back to sample width, with clamp.
module wb_norm #(
    parameter int unsigned IN_W  = 58,
    parameter int unsigned SHIFT = 34,
    parameter int unsigned OUT_W = 24
) (
    input  logic [IN_W-1:0]  sum_i,
    output logic [OUT_W-1:0] val_o
);
    localparam logic [IN_W-1:0] CEIL = IN_W'({OUT_W{1'b1}});

    logic [IN_W-1:0] scaled;

    always_comb begin
        scaled = sum_i >> SHIFT;
        if (scaled > CEIL) begin
            val_o = '1;
        end else begin
            val_o = scaled[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/wb_sum_stage.sv
// Stage two: lane total, normalization and the registered output.
module wb_sum_stage #(
    parameter int unsigned NUM_SRC     = wave_blend_pkg::DEF_NUM_SRC,
    parameter int unsigned SAMP_W      = wave_blend_pkg::DEF_SAMP_W,
    parameter int unsigned GAIN_W      = wave_blend_pkg::DEF_GAIN_W,
    parameter int unsigned HEADROOM_SH = $clog2(NUM_SRC),
    localparam int unsigned PROD_W     = SAMP_W + GAIN_W,
    localparam int unsigned SUM_W      = PROD_W + $clog2(NUM_SRC) + 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        vld_i,
    input  logic [NUM_SRC*PROD_W-1:0]   prod_i,
    output logic                        vld_o,
    output logic [SAMP_W-1:0]           mix_o
);
    typedef struct packed {
        logic              vld;
        logic [SAMP_W-1:0] mix;
    } sum_st_t;

    sum_st_t            st_d, st_q;
    logic [SUM_W-1:0]   total;
    logic [SAMP_W-1:0]  norm_val;

    always_comb begin
        total = '0;
        for (int l = 0; l < NUM_SRC; l++) begin
            total = total + SUM_W'(prod_i[l*PROD_W +: PROD_W]);
        end
    end

    wb_norm #(
        .IN_W  (SUM_W),
        .SHIFT (GAIN_W + HEADROOM_SH),
        .OUT_W (SAMP_W)
    ) u_norm (
        .sum_i (total),
        .val_o (norm_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.mix = norm_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.vld;
    assign mix_o = st_q.mix;
endmodule

// File: rtl/wave_blend.sv
// Two-stage weighted mixer of unsigned oscillator lanes.
module wave_blend #(
    parameter int unsigned NUM_SRC     = wave_blend_pkg::DEF_NUM_SRC,
    parameter int unsigned SAMP_W      = wave_blend_pkg::DEF_SAMP_W,
    parameter int unsigned GAIN_W      = wave_blend_pkg::DEF_GAIN_W,
    parameter int unsigned HEADROOM_SH = $clog2(NUM_SRC)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_vld,
    input  logic [NUM_SRC*SAMP_W-1:0]  samp_i,
    input  logic [NUM_SRC*GAIN_W-1:0]  gain_i,
    output logic                       out_vld,
    output logic [SAMP_W-1:0]          mix_o
);
    localparam int unsigned PROD_W = SAMP_W + GAIN_W;

    logic                       s1_vld;
    logic [NUM_SRC*PROD_W-1:0]  s1_prod;

    wb_mul_stage #(
        .NUM_SRC (NUM_SRC),
        .SAMP_W  (SAMP_W),
        .GAIN_W  (GAIN_W)
    ) u_mul (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (in_vld),
        .samp_i (samp_i),
        .gain_i (gain_i),
        .vld_o  (s1_vld),
        .prod_o (s1_prod)
    );

    wb_sum_stage #(
        .NUM_SRC     (NUM_SRC),
        .SAMP_W      (SAMP_W),
        .GAIN_W      (GAIN_W),
        .HEADROOM_SH (HEADROOM_SH)
    ) u_sum (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (s1_vld),
        .prod_i (s1_prod),
        .vld_o  (out_vld),
        .mix_o  (mix_o)
    );
endmodule

// File: rtl/wave_blend_chk.sv
// Port-level properties of the mixer, attached by bind.
module wave_blend_chk #(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned SAMP_W  = 24,
    parameter int unsigned GAIN_W  = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_vld,
    input logic [NUM_SRC*GAIN_W-1:0]  gain_i,
    input logic                       out_vld,
    input logic [SAMP_W-1:0]          mix_o
);
    // cycles since reset release, saturating at 3
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R3
    latency_match_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (out_vld == $past(in_vld, 2)));

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd1) |-> (!out_vld && mix_o == '0));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd1 && !out_vld) |-> $stable(mix_o));

    // R8
    zero_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && out_vld && $past(gain_i, 2) == '0) |-> (mix_o == '0));
endmodule

bind wave_blend wave_blend_chk #(
    .NUM_SRC (NUM_SRC),
    .SAMP_W  (SAMP_W),
    .GAIN_W  (GAIN_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .gain_i  (gain_i),
    .out_vld (out_vld),
    .mix_o   (mix_o)
);

// File: tb/wave_blend_bench.sv
module wave_blend_bench;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic [N*24-1:0] samp = '0;
    logic [N*32-1:0] gain = '0;
    logic          out_vld;
    logic [23:0]   mix;

    logic          s_vld = 1'b0;
    logic [47:0]   s_samp = '0;
    logic [63:0]   s_gain = '0;
    logic          s_out_vld;
    logic [23:0]   s_mix;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;
    logic [23:0] last_mix = '0;

    typedef struct {
        logic [23:0] val;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wave_blend u_wave_blend (
        .clk(clk), .rst(rst), .in_vld(in_vld), .samp_i(samp), .gain_i(gain),
        .out_vld(out_vld), .mix_o(mix)
    );

    wave_blend #(.NUM_SRC(2), .HEADROOM_SH(0)) u_sat (
        .clk(clk), .rst(rst), .in_vld(s_vld), .samp_i(s_samp), .gain_i(s_gain),
        .out_vld(s_out_vld), .mix_o(s_mix)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [23:0] clamp_ref(input logic [63:0] acc, input int sh);
        logic [63:0] v;
        v = acc >> (32 + sh);
        return (v > 64'hFFFFFF) ? 24'hFFFFFF : v[23:0];
    endfunction

    function automatic logic [23:0] ref_mix(input logic [N*24-1:0] s, input logic [N*32-1:0] g);
        logic [63:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) acc += 64'(s[i*24 +: 24]) * 64'(g[i*32 +: 32]);
        return clamp_ref(acc, 2);
    endfunction

    task automatic send(input logic [N*24-1:0] s, input logic [N*32-1:0] g, input string tag);
        exp_t e;
        @(negedge clk);
        in_vld = 1'b1;
        samp = s;
        gain = g;
        e.val = ref_mix(s, g);
        e.due = cyc + 2;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // idle cycles with changing junk on the data inputs (R10)
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            samp = {$urandom(), $urandom(), $urandom()};
            gain = {$urandom(), $urandom(), $urandom(), $urandom()};
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            if (out_vld) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R3 unexpected out_vld", 64'(out_vld), 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.due, "R3 output cycle", 64'(cyc), 64'(e.due));
                    chk(mix == e.val, e.tag, 64'(mix), 64'(e.val));
                end
                last_mix = mix;
            end else begin
                chk(mix == last_mix, "R5 hold while idle", 64'(mix), 64'(last_mix));
            end
        end
    end

    task automatic sat_case(input logic [47:0] s, input logic [63:0] g, input string tag);
        logic [63:0] acc;
        logic [23:0] exp;
        acc = 64'(s[23:0]) * 64'(g[31:0]) + 64'(s[47:24]) * 64'(g[63:32]);
        exp = clamp_ref(acc, 0);
        @(negedge clk);
        s_vld = 1'b1; s_samp = s; s_gain = g;
        @(negedge clk);
        s_vld = 1'b0;
        @(negedge clk);
        chk(s_out_vld == 1'b1, "R6 strobe", 64'(s_out_vld), 64'd1);
        chk(s_mix == exp, tag, 64'(s_mix), 64'(exp));
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        chk(out_vld == 1'b0, "R7 out_vld after reset", 64'(out_vld), 64'd0);
        chk(mix == 24'd0, "R7 mix after reset", 64'(mix), 64'd0);
        last_mix = '0;
        mon_en = 1'b1;

        // R1: hand pattern, lanes at half, quarter, full, zero gain
        send({24'h000400, 24'h800000, 24'h123456, 24'h400000},
             {32'h0, 32'hFFFFFFFF, 32'h40000000, 32'h80000000}, "R1 mixed gains");
        idle(3);
        // R2: full-scale unsigned lanes, expect 0xFFFFFE
        send({4{24'hFFFFFF}}, {4{32'hFFFFFFFF}}, "R2 full scale unsigned");
        idle(2);
        // R8: zero gains, nonzero samples
        send({24'hFFFFFF, 24'hABCDEF, 24'h7FFFFF, 24'h000001}, '0, "R8 zero gains");
        idle(2);
        // R9: 3*0.5/4 truncates to 0; 15*0.5/4 = 1.875 -> 1
        send({72'h0, 24'h000003}, {96'h0, 32'h80000000}, "R9 truncate small");
        send({72'h0, 24'h00000F}, {96'h0, 32'h80000000}, "R9 truncate fraction");
        idle(4);
        // R4: back-to-back burst of random sets
        for (int k = 0; k < 8; k++) begin
            send({$urandom(), $urandom(), $urandom()},
                 {$urandom(), $urandom(), $urandom(), $urandom()}, "R4 burst item");
        end
        // R10: long junk gap, then one exact set
        idle(6);
        send({24'h000010, 24'h000020, 24'h000030, 24'h000040}, {4{32'h80000000}}, "R10 after junk gap");
        idle(4);
        // R1: more random sets with gaps
        for (int k = 0; k < 10; k++) begin
            send({$urandom(), $urandom(), $urandom()},
                 {$urandom(), $urandom(), $urandom(), $urandom()}, "R1 random set");
            idle(k % 3);
        end
        idle(4);
        chk(sb.size() == 0, "R3 all results delivered", 64'(sb.size()), 64'd0);

        // R6: clamp on the low-headroom instance
        sat_case({24'hFFFFFF, 24'hFFFFFF}, {32'hFFFFFFFF, 32'hFFFFFFFF}, "R6 clamp full scale");
        sat_case({24'hC00000, 24'hC00000}, {32'hC0000000, 32'hC0000000}, "R6 clamp just over");
        sat_case({24'h100000, 24'h100000}, {32'h80000000, 32'h80000000}, "R6 no clamp in range");

        // R7: reset drops an in-flight set
        mon_en = 1'b0;
        @(negedge clk);
        in_vld = 1'b1;
        samp = {4{24'h800000}};
        gain = {4{32'hFFFFFFFF}};
        @(negedge clk);
        in_vld = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_vld == 1'b0, "R7 in-flight set dropped", 64'(out_vld), 64'd0);
        chk(mix == 24'd0, "R7 mix cleared", 64'(mix), 64'd0);
        @(negedge clk);
        chk(out_vld == 1'b0, "R7 no late strobe", 64'(out_vld), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule